// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single input line. It resynchronises the line into the local clock and watches it on an external tick that runs at sixteen times the bit rate. It confirms each start bit in the middle of the bit period and then samples the data and stop bits. A mode input selects 8 or 9 data bits. Each finished frame is written into a two-entry queue. The queue entry holds the byte, the ninth bit and a framing-error flag.

A consumer watches the data-available flag. It reads the head byte and its status bits from the outputs, then pulses the read strobe to move to the next entry. If a third frame completes while both entries are still occupied, that frame is dropped and a sticky overrun flag rises. Once the overrun flag is set, no further frames enter the queue. Pulling the enable low resets the receiver: it empties the queue, clears the overrun flag and sends the frame engine back to idle.

Top module: `serial_rx_buffered`

## Requirements
- R1: After reset, `data_avail` and `overrun` are 0.
- R2: The line passes through a two-flop synchronizer and is examined only on cycles where `os_tick` is 1. A low level seen on a tick starts a candidate start bit. The start bit is confirmed only if the line is still low 8 ticks later. Otherwise the event is treated as a glitch and discarded, and nothing is written into the queue.
- R3: Data bits are sampled 16 ticks apart, starting 16 ticks after the start-bit check, and are assembled least-significant bit first. With `nine_bit`=0 a frame carries 8 data bits, which appear on `head_data[7:0]`.
- R4: With `nine_bit`=1 a frame carries 9 data bits, and the ninth bit received appears on `head_bit9`. With `nine_bit`=0, `head_bit9` reads 0.
- R5: When the stop bit is sampled low, `head_ferr` is 1 for that frame's entry. When the stop bit is sampled high, `head_ferr` is 0.
- R6: The queue holds two frames in arrival order. A pulse on `rd_pop` while `data_avail` is 1 removes the head entry. From the next cycle, `head_data`, `head_bit9` and `head_ferr` show the next entry. The head outputs do not change while no read takes place.
- R7: `data_avail` is 1 whenever the queue holds at least one entry. It returns to 0 by itself in the cycle after the last entry is read.
- R8: If a frame completes while both queue entries are occupied, the frame is discarded and `overrun` becomes 1. `overrun` then remains 1 for as long as `rx_en` stays high.
- R9: While `overrun` is 1, no completed frame enters the queue, even after entries have been read. Driving `rx_en` low clears `overrun` in the next cycle.
- R10: While `rx_en` is 0, frames are not received. Driving `rx_en` low empties the queue, and `data_avail` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; low flushes and idles the receiver |
| nine_bit | input | 1 | 1 selects 9 data bits per frame, 0 selects 8 |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| rd_pop | input | 1 | Read strobe; removes the head entry |
| head_data | output | 8 | Low eight data bits of the head entry |
| head_bit9 | output | 1 | Ninth data bit of the head entry |
| head_ferr | output | 1 | Framing-error flag of the head entry |
| data_avail | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bound checker enforces several rules on every cycle:
- disabling the receiver empties the queue and clears `overrun`;
- `overrun` stays set while the receiver remains enabled;
- a blocked queue never gains an entry;
- the head outputs hold steady when no read takes place.

The directed scenarios cover what a cycle-local property cannot express. These are bit assembly, glitch rejection at the start-bit check, the ninth-bit mode, and per-entry status advancing on a read. They also include a third frame lost to overrun and recovery after the enable is toggled.

// File: rtl/serial_rx_pkg.sv
// Shared types for the buffered serial receiver.
// Assumes at most nine data bits per frame.
package serial_rx_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAX_BITS = BYTE_W + 1;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit9;
        logic              ferr;
    } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchronizer for an asynchronous input line.
// Assumes the line idles high, so every stage resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) q[i] <= 1'b1;
                else        q[i] <= d_async;
            end
        end else begin : g_next
            // Later stages pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) q[i] <= 1'b1;
                else        q[i] <= q[i-1];
            end
        end
    end

    assign d_sync = q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
// Frame engine: detects a start bit, confirms it at mid-bit, then samples the
// data bits (LSB first) and the stop bit every OSR ticks.
// It emits a one-cycle frame_done pulse carrying the assembled entry.
// Assumes rx_s is already synchronous and os_tick is a one-cycle pulse.
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      nine_bit,
    input  logic      os_tick,
    input  logic      rx_s,
    output logic      frame_done,
    output rx_entry_t frame
);
    localparam int CW    = $clog2(OSR);
    localparam int IW    = $clog2(MAX_BITS + 1);
    localparam int MID   = OSR / 2 - 1;
    localparam int LAST  = OSR - 1;

    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} state_t;

    state_t              state;
    logic [CW-1:0]       tcnt;
    logic [IW-1:0]       bidx;
    logic [MAX_BITS-1:0] shreg;
    logic [IW-1:0]       nbits;

    assign nbits = nine_bit ? IW'(MAX_BITS) : IW'(BYTE_W);

    // Sequencer: start detection, mid-bit sampling and the frame-done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state      <= S_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            frame      <= '0;
        end else begin
            frame_done <= 1'b0;
            if (os_tick) begin
                unique case (state)
                    S_IDLE: begin
                        if (!rx_s) begin
                            state <= S_START;
                            tcnt  <= '0;
                        end
                    end
                    S_START: begin
                        if (tcnt == CW'(MID)) begin
                            tcnt  <= '0;
                            bidx  <= '0;
                            shreg <= '0;
                            state <= rx_s ? S_IDLE : S_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (tcnt == CW'(LAST)) begin
                            tcnt        <= '0;
                            shreg[bidx] <= rx_s;
                            if (bidx == nbits - 1'b1) state <= S_STOP;
                            else                      bidx  <= bidx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (tcnt == CW'(LAST)) begin
                            tcnt       <= '0;
                            state      <= S_IDLE;
                            frame_done <= 1'b1;
                            frame.data <= shreg[BYTE_W-1:0];
                            frame.bit9 <= nine_bit & shreg[BYTE_W];
                            frame.ferr <= ~rx_s;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_pair_fifo.sv
// Small receive queue of DEPTH entries with a flush.
// The head entry is always presented on the output.
// Assumes the caller never pushes when full and never pops when empty.
module rx_pair_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  rx_entry_t                  wr_entry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Entry storage: write on push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_entry;
    end

    // Pointers and occupancy; a flush or reset empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + NW'(1);
                2'b01:   count <= count - NW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/serial_rx_buffered.sv
// Buffered asynchronous serial receiver top.
// Chains the synchronizer, the frame engine and the receive queue, and owns
// the sticky overrun flag. Assumes os_tick is a one-cycle pulse at OSR times
// the bit rate. rx_en low flushes the queue and clears the overrun flag.
module serial_rx_buffered
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              rd_pop,
    output logic [BYTE_W-1:0] head_data,
    output logic              head_bit9,
    output logic              head_ferr,
    output logic              data_avail,
    output logic              overrun
);
    localparam int NW = $clog2(DEPTH + 1);

    logic          rx_s;
    logic          frame_done;
    rx_entry_t     frame;
    rx_entry_t     head;
    logic [NW-1:0] count;
    logic          full, push, pop;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_in),
        .d_sync  (rx_s)
    );

    rx_frame_engine #(.OSR(OSR)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .nine_bit   (nine_bit),
        .os_tick    (os_tick),
        .rx_s       (rx_s),
        .frame_done (frame_done),
        .frame      (frame)
    );

    assign full = (count == NW'(DEPTH));
    assign push = frame_done & rx_en & ~overrun & ~full;
    assign pop  = rd_pop & data_avail;

    rx_pair_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (~rx_en),
        .push     (push),
        .wr_entry (frame),
        .pop      (pop),
        .head     (head),
        .count    (count)
    );

    // Sticky overrun: set by a frame arriving into a full queue, cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en)                 overrun <= 1'b0;
        else if (frame_done && full)          overrun <= 1'b1;
    end

    assign data_avail = (count != '0);
    assign head_data  = head.data;
    assign head_bit9  = head.bit9;
    assign head_ferr  = head.ferr;
endmodule

// File: rtl/serial_rx_buffered_checker.sv
// Cycle-level properties of the buffered receiver, attached by bind.
// Observes only top-level ports.
module serial_rx_buffered_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_pop,
    input logic [7:0] head_data,
    input logic       head_bit9,
    input logic       head_ferr,
    input logic       data_avail,
    input logic       overrun
);
    // R10: disabling empties the queue on the next cycle.
    p_flush_on_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !data_avail);

    // R9: disabling clears the overrun flag on the next cycle.
    p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun);

    // R8: overrun stays set while enabled.
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);

    // R9: an empty queue under overrun stays empty.
    p_no_fill_in_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en && !data_avail) |=> !data_avail);

    // R6: head outputs hold when nothing is read.
    p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && data_avail && !rd_pop) |=>
            ($stable(head_data) && $stable(head_bit9) && $stable(head_ferr)));
endmodule

bind serial_rx_buffered serial_rx_buffered_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rd_pop     (rd_pop),
    .head_data  (head_data),
    .head_bit9  (head_bit9),
    .head_ferr  (head_ferr),
    .data_avail (data_avail),
    .overrun    (overrun)
);

// File: tb/serial_rx_buffered_bench.sv
// Directed bench for serial_rx_buffered: one task per scenario.
module serial_rx_buffered_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;
    localparam int OSR        = 16;
    localparam int GAP_TICKS  = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       rd_pop = 1'b0;
    logic [7:0] head_data;
    logic       head_bit9, head_ferr, data_avail, overrun;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_buffered u_serial_rx_buffered (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .nine_bit   (nine_bit),
        .os_tick    (os_tick),
        .rx_in      (rx_in),
        .rd_pop     (rd_pop),
        .head_data  (head_data),
        .head_bit9  (head_bit9),
        .head_ferr  (head_ferr),
        .data_avail (data_avail),
        .overrun    (overrun)
    );

    // Tick generator: one-cycle pulse every TICK_DIV clocks, driven on the falling edge.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV - 1);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rx_in = v;
        wait_ticks(OSR);
    endtask

    task automatic send_frame(input logic [8:0] val, input int nbits, input logic stop_v);
        drive_bit(1'b0);
        for (int i = 0; i < nbits; i++) drive_bit(val[i]);
        drive_bit(stop_v);
        @(negedge clk);
        rx_in = 1'b1;
        wait_ticks(GAP_TICKS);
        @(negedge clk);
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic toggle_enable();
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data_avail after reset", data_avail, 0);
        chk("R1 overrun after reset", overrun, 0);
    endtask

    task automatic t_basic();
        nine_bit = 1'b0;
        send_frame(9'h0A5, 8, 1'b1);
        chk("R7 avail after one frame", data_avail, 1);
        chk("R3 byte LSB first", head_data, 8'hA5);
        chk("R5 good stop no ferr", head_ferr, 0);
        chk("R4 bit9 zero in 8-bit mode", head_bit9, 0);
        pop_one();
        chk("R7 avail drops after last read", data_avail, 0);
        send_frame(9'h13C, 8, 1'b1);
        chk("R3 second pattern", head_data, 8'h3C);
        chk("R4 bit9 zero in 8-bit mode, high bit driven", head_bit9, 0);
        pop_one();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rx_in = 1'b0;
        wait_ticks(3);
        @(negedge clk);
        rx_in = 1'b1;
        wait_ticks(OSR * 12);
        @(negedge clk);
        chk("R2 glitch produces no entry", data_avail, 0);
        send_frame(9'h05A, 8, 1'b1);
        chk("R2 frame after glitch", head_data, 8'h5A);
        pop_one();
    endtask

    task automatic t_nine();
        nine_bit = 1'b1;
        send_frame(9'h1C3, 9, 1'b1);
        chk("R4 nine-bit byte", head_data, 8'hC3);
        chk("R4 ninth bit set", head_bit9, 1);
        pop_one();
        nine_bit = 1'b0;
    endtask

    task automatic t_status();
        nine_bit = 1'b1;
        send_frame(9'h111, 9, 1'b1);
        send_frame(9'h022, 9, 1'b0);
        chk("R6 first entry data", head_data, 8'h11);
        chk("R6 first entry bit9", head_bit9, 1);
        chk("R5 first entry ferr", head_ferr, 0);
        pop_one();
        chk("R6 second entry data", head_data, 8'h22);
        chk("R6 second entry bit9", head_bit9, 0);
        chk("R5 stop low sets ferr", head_ferr, 1);
        chk("R7 avail with one left", data_avail, 1);
        pop_one();
        chk("R7 avail drops after both reads", data_avail, 0);
        nine_bit = 1'b0;
    endtask

    task automatic t_overrun();
        send_frame(9'h0A1, 8, 1'b1);
        send_frame(9'h0B2, 8, 1'b1);
        chk("R8 no overrun with two entries", overrun, 0);
        send_frame(9'h0C3, 8, 1'b1);
        chk("R8 overrun set by third frame", overrun, 1);
        chk("R8 head still first frame", head_data, 8'hA1);
        pop_one();
        chk("R8 second entry kept", head_data, 8'hB2);
        pop_one();
        chk("R8 third frame discarded", data_avail, 0);
        send_frame(9'h0D4, 8, 1'b1);
        chk("R9 blocked while overrun", data_avail, 0);
        chk("R8 overrun still set", overrun, 1);
        toggle_enable();
        chk("R9 overrun cleared by toggle", overrun, 0);
        send_frame(9'h0E5, 8, 1'b1);
        chk("R9 reception resumes", head_data, 8'hE5);
        chk("R9 entry present after recovery", data_avail, 1);
        pop_one();
    endtask

    task automatic t_disable();
        send_frame(9'h066, 8, 1'b1);
        send_frame(9'h077, 8, 1'b1);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R10 flush on disable", data_avail, 0);
        send_frame(9'h088, 8, 1'b1);
        chk("R10 no reception while disabled", data_avail, 0);
        rx_en = 1'b1;
        @(negedge clk);
        send_frame(9'h099, 8, 1'b1);
        chk("R10 reception after re-enable", head_data, 8'h99);
        pop_one();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        @(negedge clk);
        t_basic();
        t_glitch();
        t_nine();
        t_status();
        t_overrun();
        t_disable();
        finish_run();
    end
endmodule